// File: doc/BRIEF.md
# Buffered Serial Port Register Block

This block is the software-facing side of a serial port with a receive buffer. A processor reaches it through a small register bus. Each access is one cycle and carries an address, a write strobe with write data, or a read strobe. Read data is combinational from the current state. The read side effects, which are a receive pop and the re-arming of the transmit flags, take effect at the clock edge that ends the read cycle.

On the line side, a receiver that has already assembled whole bytes delivers them through a valid/data pair. A separate pulse reports a break condition. The block queues received bytes in a circular buffer and raises a ready flag once the fill reaches a programmable threshold. Bytes written for transmission appear on a valid/data pair one cycle after the write. Two interrupt lines report receive readiness and transmit enable.

Software clears status flags by writing zero to the bit of each flag it acknowledges. Writing a one leaves that flag as it is. Reading the status while the transmitter is enabled sets both transmit flags again.

Top module: `sfifo_serial_regs`

## Requirements
- R1: After reset the registers read as follows: mode 0x00, bit rate 0xFF, control 0x20, buffer control 0x00, port 0x00, status 0x60 (transmit-end and transmit-empty set), fill count 0. The receive trigger level is 1 and both interrupts are low.
- R2: Offsets are mode 0x00, bit rate 0x04, control 0x08, transmit data 0x0C, status 0x10, receive data 0x14, buffer control 0x18, fill count 0x1C, port 0x20 and a zero register at 0x24. The bus keeps only the bits 0x7B of a mode write, 0xFA of a control write and 0xF3 of a port write. Bit-rate and buffer-control writes are stored whole.
- R3: Status bit 6 is transmit-end, bit 5 is transmit-empty, bit 4 is break, bit 1 is receive-ready and bit 0 is data-ready. Writing 0 to one of these bits clears that flag and writing 1 leaves it unchanged. A pulse on `brk_in` sets break, and this set wins over a clear in the same cycle.
- R4: Buffer-control bits 7:6 choose the trigger level: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. When a stored byte brings the fill to the trigger level or above, receive-ready is set.
- R5: The buffer holds 16 bytes in arrival order. A byte is taken only while control bit 4 is 1 and the buffer is not full. Any other byte is dropped.
- R6: A read of 0x14 returns the oldest byte and removes it, or returns 0 when the buffer is empty. If the fill then falls below the trigger level and no byte is stored in that cycle, receive-ready clears. A read of 0x1C returns the fill count.
- R7: `rx_irq` rises together with receive-ready when a byte is stored while control bit 6 is 1. It falls on a control write with bit 6 at 0, or on a status write with bit 1 or bit 0 at 0. A byte stored in the same cycle takes precedence over either clear.
- R8: A write to 0x0C drives `tx_valid` high for exactly the next cycle, with `tx_data` equal to the written byte, and clears transmit-empty.
- R9: A control write with bit 5 at 0 sets transmit-end. A status read while control bit 5 is 1 returns the flags as they stood, then sets transmit-end and transmit-empty.
- R10: `tx_irq` equals control bit 7 from the cycle after the control write.
- R11: A buffer-control write with bit 1 at 1 empties the buffer. A byte arriving in that cycle is dropped.
- R12: Reads of 0x24, 0x0C and unmapped offsets return 0. Writes to 0x1C, 0x24 and unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; its side effects apply at the edge that ends the cycle |
| bus_rdata | output | 8 | Read data for the offset on `bus_addr` |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| brk_in | input | 1 | Break-detected pulse |
| tx_valid | output | 1 | Outgoing byte is present (one cycle) |
| tx_data | output | 8 | Outgoing byte |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. One property checks that assumption, and the stimulus issues at most one bus operation per cycle. The full-buffer and interrupt-drop properties hold only when no receive pop, flush or stored byte falls in the same cycle, so their antecedents name that condition. The random phase then drives the line inputs and the bus independently, which keeps those overlaps in play for the bench's model comparison.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int unsigned DW = 8;
    localparam int unsigned AW = 6;

    localparam logic [AW-1:0] OFF_MODE = 6'h00;
    localparam logic [AW-1:0] OFF_BAUD = 6'h04;
    localparam logic [AW-1:0] OFF_CTRL = 6'h08;
    localparam logic [AW-1:0] OFF_TXD  = 6'h0C;
    localparam logic [AW-1:0] OFF_STAT = 6'h10;
    localparam logic [AW-1:0] OFF_RXD  = 6'h14;
    localparam logic [AW-1:0] OFF_FCTL = 6'h18;
    localparam logic [AW-1:0] OFF_RCNT = 6'h1C;
    localparam logic [AW-1:0] OFF_PORT = 6'h20;
    localparam logic [AW-1:0] OFF_ZERO = 6'h24;

    localparam logic [DW-1:0] MODE_KEEP = 8'h7B;
    localparam logic [DW-1:0] CTRL_KEEP = 8'hFA;
    localparam logic [DW-1:0] PORT_KEEP = 8'hF3;
    localparam logic [DW-1:0] BAUD_INIT = 8'hFF;
    localparam logic [DW-1:0] CTRL_INIT = 8'h20;

    localparam int unsigned C_RXEN = 4;
    localparam int unsigned C_TXEN = 5;
    localparam int unsigned C_RIE  = 6;
    localparam int unsigned C_TIE  = 7;
    localparam int unsigned F_FLUSH = 1;

    typedef struct packed {
        logic tend;
        logic tde;
        logic brk;
        logic rdf;
        logic dr;
    } flags_t;

    function automatic logic [4:0] trig_of(input logic [1:0] sel);
        logic [4:0] t;
        unique case (sel)
            2'd0: t = 5'd1;
            2'd1: t = 5'd4;
            2'd2: t = 5'd8;
            default: t = 5'd14;
        endcase
        return t;
    endfunction
endpackage

// File: rtl/ssr_cfg_regs.sv
module ssr_cfg_regs
    import ssr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mode_q,
    output logic [DW-1:0] baud_q,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] fctl_q,
    output logic [DW-1:0] port_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            baud_q <= BAUD_INIT;
            ctrl_q <= CTRL_INIT;
            fctl_q <= '0;
            port_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFF_MODE: mode_q <= wdata & MODE_KEEP;
                OFF_BAUD: baud_q <= wdata;
                OFF_CTRL: ctrl_q <= wdata & CTRL_KEEP;
                OFF_FCTL: fctl_q <= wdata;
                OFF_PORT: port_q <= wdata & PORT_KEEP;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ssr_rx_fifo.sv
module ssr_rx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head  = mem[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/ssr_status.sv
module ssr_status
    import ssr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   stat_rd,
    input  logic   txen,
    input  logic   rie,
    input  logic   stat_wr,
    input  flags_t stat_keep,
    input  logic   ctrl_wr,
    input  logic   ctrl_txen_w,
    input  logic   ctrl_rie_w,
    input  logic   txd_wr,
    input  logic   brk_pulse,
    input  logic   push_ok,
    input  logic   pop_ok,
    input  logic   at_trig,
    output flags_t flags_q,
    output logic   irq_q
);
    flags_t flags_n;
    logic   irq_n;

    always_comb begin
        flags_n = flags_q;
        irq_n   = irq_q;
        if (stat_rd && txen) begin
            flags_n.tend = 1'b1;
            flags_n.tde  = 1'b1;
        end
        if (stat_wr) begin
            flags_n = flags_n & stat_keep;
            if (!stat_keep.rdf || !stat_keep.dr) irq_n = 1'b0;
        end
        if (ctrl_wr) begin
            if (!ctrl_txen_w) flags_n.tend = 1'b1;
            if (!ctrl_rie_w)  irq_n = 1'b0;
        end
        if (txd_wr)    flags_n.tde = 1'b0;
        if (brk_pulse) flags_n.brk = 1'b1;
        if (push_ok) begin
            if (at_trig) begin
                flags_n.rdf = 1'b1;
                if (rie) irq_n = 1'b1;
            end
        end else if (pop_ok && !at_trig) begin
            flags_n.rdf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '{tend: 1'b1, tde: 1'b1, default: 1'b0};
            irq_q   <= 1'b0;
        end else begin
            flags_q <= flags_n;
            irq_q   <= irq_n;
        end
    end
endmodule

// File: rtl/sfifo_serial_regs.sv
module sfifo_serial_regs
    import ssr_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          brk_in,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          rx_irq,
    output logic          tx_irq
);
    logic [DW-1:0] mode_q, baud_q, ctrl_q, fctl_q, port_q, rx_head;
    logic [CW-1:0] rx_count, cnt_next;
    logic          rx_full, rx_empty, push_ok, pop_ok, flush, at_trig;
    flags_t        flags_q, stat_keep;

    logic wr_ctrl, wr_txd, wr_stat, rd_stat, rd_rxd;
    assign wr_ctrl = bus_wr && (bus_addr == OFF_CTRL);
    assign wr_txd  = bus_wr && (bus_addr == OFF_TXD);
    assign wr_stat = bus_wr && (bus_addr == OFF_STAT);
    assign rd_stat = bus_rd && (bus_addr == OFF_STAT);
    assign rd_rxd  = bus_rd && (bus_addr == OFF_RXD);
    assign flush   = bus_wr && (bus_addr == OFF_FCTL) && bus_wdata[F_FLUSH];

    assign push_ok  = rx_valid && ctrl_q[C_RXEN] && !rx_full && !flush;
    assign pop_ok   = rd_rxd && !rx_empty;
    assign cnt_next = rx_count + CW'(push_ok) - CW'(pop_ok);
    assign at_trig  = 8'(cnt_next) >= 8'(trig_of(fctl_q[7:6]));

    assign stat_keep = '{tend: bus_wdata[6], tde: bus_wdata[5], brk: bus_wdata[4],
                         rdf: bus_wdata[1], dr: bus_wdata[0]};

    ssr_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .mode_q(mode_q), .baud_q(baud_q), .ctrl_q(ctrl_q), .fctl_q(fctl_q), .port_q(port_q)
    );

    ssr_rx_fifo #(.DEPTH(DEPTH), .W(DW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop_ok), .flush(flush),
        .wdata(rx_data), .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    ssr_status u_stat (
        .clk(clk), .rst_n(rst_n), .stat_rd(rd_stat), .txen(ctrl_q[C_TXEN]),
        .rie(ctrl_q[C_RIE]), .stat_wr(wr_stat), .stat_keep(stat_keep),
        .ctrl_wr(wr_ctrl), .ctrl_txen_w(bus_wdata[C_TXEN]), .ctrl_rie_w(bus_wdata[C_RIE]),
        .txd_wr(wr_txd), .brk_pulse(brk_in), .push_ok(push_ok), .pop_ok(pop_ok),
        .at_trig(at_trig), .flags_q(flags_q), .irq_q(rx_irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= wr_txd;
            if (wr_txd) tx_data <= bus_wdata;
        end
    end

    assign tx_irq = ctrl_q[C_TIE];

    always_comb begin
        unique case (bus_addr)
            OFF_MODE: bus_rdata = mode_q;
            OFF_BAUD: bus_rdata = baud_q;
            OFF_CTRL: bus_rdata = ctrl_q;
            OFF_STAT: bus_rdata = {1'b0, flags_q.tend, flags_q.tde, flags_q.brk,
                                   2'b00, flags_q.rdf, flags_q.dr};
            OFF_RXD:  bus_rdata = rx_empty ? '0 : rx_head;
            OFF_FCTL: bus_rdata = fctl_q;
            OFF_RCNT: bus_rdata = 8'(rx_count);
            OFF_PORT: bus_rdata = port_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker
    import ssr_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_rd,
    input logic          rx_valid,
    input logic          brk_in,
    input logic          tx_valid,
    input logic [DW-1:0] tx_data,
    input logic          rx_irq,
    input logic          tx_irq,
    input logic [CW-1:0] rx_count,
    input logic          brk_flag,
    input logic          tend_flag
);
    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH)); // R5
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == CW'(DEPTH) && !bus_rd && !bus_wr) |=> rx_count == CW'(DEPTH)); // R5
    AST_TX_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_TXD) |=> (tx_valid && tx_data == $past(bus_wdata))); // R8
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFF_TXD) |=> !tx_valid); // R8
    AST_TIRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_CTRL) |=> tx_irq == $past(bus_wdata[7])); // R10
    AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        brk_in |=> brk_flag); // R3
    AST_TEND_TXOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_CTRL && !bus_wdata[5]) |=> tend_flag); // R9
    AST_RIRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_CTRL && !bus_wdata[6] && !rx_valid) |=> !rx_irq); // R7
endmodule

bind sfifo_serial_regs ssr_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .rx_valid(rx_valid), .brk_in(brk_in), .tx_valid(tx_valid),
    .tx_data(tx_data), .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_count(rx_count),
    .brk_flag(flags_q.brk), .tend_flag(flags_q.tend)
);

// File: tb/sfifo_serial_regs_tb_top.sv
module sfifo_serial_regs_tb_top;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, rx_valid = 1'b0, brk_in = 1'b0;
    logic [7:0] bus_wdata = '0, rx_data = '0;
    logic [7:0] bus_rdata, tx_data;
    logic       tx_valid, rx_irq, tx_irq;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    sfifo_serial_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .brk_in(brk_in), .tx_valid(tx_valid), .tx_data(tx_data), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    // behavioural reference model
    logic [7:0] q[$];
    logic [7:0] m_mode, m_baud, m_ctrl, m_fctl, m_port, m_txd;
    bit m_tend, m_tde, m_brk, m_rdf, m_dr, m_irq, m_txv;

    function automatic int trig(input logic [1:0] s);
        case (s) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
    endfunction

    function automatic logic [7:0] m_read(input logic [5:0] a);
        case (a)
            6'h00: return m_mode;
            6'h04: return m_baud;
            6'h08: return m_ctrl;
            6'h10: return {1'b0, m_tend, m_tde, m_brk, 2'b00, m_rdf, m_dr};
            6'h14: return (q.size() > 0) ? q[0] : 8'h00;
            6'h18: return m_fctl;
            6'h1C: return 8'(q.size());
            6'h20: return m_port;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        case (a)
            6'h10: return "R3";
            6'h14: return "R6";
            6'h1C: return "R6";
            6'h18: return "R4";
            6'h00, 6'h04, 6'h08, 6'h20: return "R2";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            m_mode = 0; m_baud = 8'hFF; m_ctrl = 8'h20; m_fctl = 0; m_port = 0; m_txd = 0;
            m_tend = 1; m_tde = 1; m_brk = 0; m_rdf = 0; m_dr = 0; m_irq = 0; m_txv = 0;
        end else begin
            automatic logic [7:0] oc = m_ctrl;
            automatic int tl = trig(m_fctl[7:6]);
            automatic bit fl = bus_wr && bus_addr == 6'h18 && bus_wdata[1];
            automatic bit pu = rx_valid && oc[4] && q.size() < 16 && !fl;
            automatic bit po = bus_rd && bus_addr == 6'h14 && q.size() > 0;
            m_txv = bus_wr && bus_addr == 6'h0C;
            if (m_txv) m_txd = bus_wdata;
            if (bus_rd && bus_addr == 6'h10 && oc[5]) begin m_tend = 1; m_tde = 1; end
            if (bus_wr) case (bus_addr)
                6'h00: m_mode = bus_wdata & 8'h7B;
                6'h04: m_baud = bus_wdata;
                6'h08: begin
                    m_ctrl = bus_wdata & 8'hFA;
                    if (!bus_wdata[5]) m_tend = 1;
                    if (!bus_wdata[6]) m_irq = 0;
                end
                6'h0C: m_tde = 0;
                6'h10: begin
                    m_tend &= bus_wdata[6]; m_tde &= bus_wdata[5]; m_brk &= bus_wdata[4];
                    m_rdf &= bus_wdata[1]; m_dr &= bus_wdata[0];
                    if (!bus_wdata[1] || !bus_wdata[0]) m_irq = 0;
                end
                6'h18: m_fctl = bus_wdata;
                6'h20: m_port = bus_wdata & 8'hF3;
                default: ;
            endcase
            if (brk_in) m_brk = 1;
            if (fl) q.delete();
            if (po) void'(q.pop_front());
            if (pu) begin
                q.push_back(rx_data);
                if (q.size() >= tl) begin m_rdf = 1; if (oc[6]) m_irq = 1; end
            end else if (po && q.size() < tl) m_rdf = 0;
        end
    end

    always @(negedge clk) if (rst_n) begin
        check("R7", {7'd0, rx_irq}, {7'd0, m_irq});
        check("R10", {7'd0, tx_irq}, {7'd0, m_ctrl[7]});
        check("R8", {7'd0, tx_valid}, {7'd0, m_txv});
        if (m_txv) check("R8", tx_data, m_txd);
        if (bus_rd) check(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
    end

    // one bus/line cycle
    task automatic cyc(input bit w, input bit r, input logic [5:0] a, input logic [7:0] d,
                       input bit rv, input logic [7:0] rd, input bit bk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        rx_valid = rv; rx_data = rd; brk_in = bk;
        @(posedge clk); #1;
        bus_wr = 0; bus_rd = 0; rx_valid = 0; brk_in = 0;
    endtask
    task automatic wr(input logic [5:0] a, input logic [7:0] d); cyc(1, 0, a, d, 0, 0, 0); endtask
    task automatic rxb(input logic [7:0] d); cyc(0, 0, 0, 0, 1, d, 0); endtask
    task automatic rd_exp(input logic [5:0] a, input logic [7:0] e, input string tag);
        bus_rd = 1; bus_addr = a;
        @(negedge clk); check(tag, bus_rdata, e);
        @(posedge clk); #1; bus_rd = 0;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #1; rst_n = 1;
        @(posedge clk); #1;
        // R1 reset state
        rd_exp(6'h00, 8'h00, "R1"); rd_exp(6'h04, 8'hFF, "R1"); rd_exp(6'h08, 8'h20, "R1");
        rd_exp(6'h10, 8'h60, "R1"); rd_exp(6'h18, 8'h00, "R1"); rd_exp(6'h1C, 8'h00, "R1");
        rd_exp(6'h20, 8'h00, "R1");
        // R12 zero and unmapped
        rd_exp(6'h24, 8'h00, "R12"); rd_exp(6'h3C, 8'h00, "R12"); rd_exp(6'h14, 8'h00, "R12");
        wr(6'h3C, 8'hAA); wr(6'h24, 8'h55); wr(6'h1C, 8'h07);
        rd_exp(6'h1C, 8'h00, "R12"); rd_exp(6'h00, 8'h00, "R12");
        // R2 masks
        wr(6'h00, 8'hFF); rd_exp(6'h00, 8'h7B, "R2");
        wr(6'h20, 8'hFF); rd_exp(6'h20, 8'hF3, "R2");
        wr(6'h04, 8'h5A); rd_exp(6'h04, 8'h5A, "R2");
        wr(6'h08, 8'hFF); rd_exp(6'h08, 8'hFA, "R2");
        @(negedge clk); check("R10", {7'd0, tx_irq}, 8'h01); @(posedge clk); #1;
        // R5 receive disabled
        wr(6'h08, 8'h20); rxb(8'h11); rd_exp(6'h1C, 8'h00, "R5");
        @(negedge clk); check("R10", {7'd0, tx_irq}, 8'h00); @(posedge clk); #1;
        // R4 trigger 4, R7 interrupt
        wr(6'h08, 8'h70); wr(6'h18, 8'h40);
        rxb(8'hA1); rxb(8'hA2); rxb(8'hA3);
        rd_exp(6'h10, 8'h60, "R4");
        @(negedge clk); check("R7", {7'd0, rx_irq}, 8'h00); @(posedge clk); #1;
        rxb(8'hA4);
        @(negedge clk); check("R7", {7'd0, rx_irq}, 8'h01); @(posedge clk); #1;
        rd_exp(6'h10, 8'h62, "R4");
        // R6 pop
        rd_exp(6'h14, 8'hA1, "R6"); rd_exp(6'h10, 8'h60, "R6"); rd_exp(6'h1C, 8'h03, "R6");
        wr(6'h10, 8'hFD);
        @(negedge clk); check("R7", {7'd0, rx_irq}, 8'h00); @(posedge clk); #1;
        // R5 fill past full, order and wrap
        for (int i = 0; i < 20; i++) rxb(8'(8'hB0 + i));
        rd_exp(6'h1C, 8'h10, "R5");
        for (int i = 0; i < 3; i++) rd_exp(6'h14, 8'(8'hA2 + i), "R5");
        for (int i = 0; i < 13; i++) rd_exp(6'h14, 8'(8'hB0 + i), "R5");
        rd_exp(6'h1C, 8'h00, "R5");
        // R11 flush, R4 trigger 14
        wr(6'h18, 8'hC0);
        for (int i = 0; i < 13; i++) rxb(8'(i));
        rd_exp(6'h10, 8'h60, "R4");
        rxb(8'h0D); rd_exp(6'h10, 8'h62, "R4");
        cyc(1, 0, 6'h18, 8'h02, 1, 8'hEE, 0);
        rd_exp(6'h1C, 8'h00, "R11");
        // R8 / R9 transmit flags
        wr(6'h0C, 8'h3C);
        rd_exp(6'h10, 8'h42, "R8"); rd_exp(6'h10, 8'h62, "R9");
        wr(6'h08, 8'h10); wr(6'h10, 8'h9F);
        rd_exp(6'h10, 8'h02, "R3"); rd_exp(6'h10, 8'h02, "R9");
        wr(6'h08, 8'h00); rd_exp(6'h10, 8'h42, "R9");
        // R3 break
        cyc(0, 0, 0, 0, 0, 0, 1); rd_exp(6'h10, 8'h52, "R3");
        cyc(1, 0, 6'h10, 8'hEF, 0, 0, 1); rd_exp(6'h10, 8'h52, "R3");
        wr(6'h10, 8'hEF); rd_exp(6'h10, 8'h42, "R3");
        // random mix, compared against the model every cycle
        for (int n = 0; n < 4000; n++) begin
            automatic int op = $urandom_range(0, 9);
            automatic logic [5:0] a = (op == 9) ? 6'($urandom_range(0, 63))
                                               : 6'(4 * $urandom_range(0, 9));
            automatic logic [7:0] d = 8'($urandom);
            if (a == 6'h18 && $urandom_range(0, 3) != 0) d[1] = 1'b0;
            cyc(op inside {[5:7]}, op inside {[0:4], 9}, a, d,
                $urandom_range(0, 1) == 1, 8'($urandom), $urandom_range(0, 19) == 0);
        end
        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule